// File: doc/BRIEF.md
# Banked Tri-State Output Enable Control

This block decides, for each of sixteen bidirectional I/O cells, whether the cell drives its pad. The cells form two groups of eight. Each group shares a small pool of two enable terms that are computed elsewhere. A 2-bit setting per cell makes the buffer permanently off, permanently on, or follows one of the two terms of its own group. A cell cannot select a term that belongs to the other group.

The pad is modelled as three separate signals: the value offered to the pad, the enable, and the value that comes back from the pad. The returned value is the pin level in every case. It equals the cell's own data while the cell drives, and otherwise it equals whatever the outside world applies. The same cell can therefore act as an output, a shared-bus driver, an input or a bidirectional pin. The whole path is combinational.

Top module: `oe_bank_ctrl`

## Requirements
- R1: A cell whose mode field is 2'b00 has its enable output low, whatever the enable terms are.
- R2: A cell whose mode field is 2'b01 has its enable output high, whatever the enable terms are.
- R3: A cell whose mode field is 2'b10 has its enable equal to the first term of its own bank. Bank k's first term is `bank_term[2k]`. Cells 0..7 are bank 0 and cells 8..15 are bank 1.
- R4: A cell whose mode field is 2'b11 has its enable equal to the second term of its own bank, `bank_term[2k+1]`.
- R5: The terms of one bank have no effect on any enable or feedback value of the other bank's cells.
- R6: Each cell's pad data output equals its macrocell data input in every mode.
- R7: Each feedback bit equals the cell's macrocell data when the cell is enabled, and the external pad drive when it is not. A disabled cell's own data never reaches its feedback.
- R8: All outputs follow their inputs without any clock edge. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mc_data | input | 16 | Macrocell data for each cell |
| bank_term | input | 4 | Shared enable terms. Bank k uses bits 2k (first) and 2k+1 (second) |
| cell_mode | input | 32 | Mode of cell i in bits [2i+1:2i]: 00 off, 01 on, 10 first term, 11 second term |
| pad_ext | input | 16 | Level applied to each pad from outside when the cell does not drive it |
| pad_out | output | 16 | Data offered to each pad |
| pad_oe | output | 16 | Output enable of each pad buffer |
| fb_in | output | 16 | Pin level returned as I/O feedback |

## Verification
The hardest case to reach is bank isolation. Both banks have to be in term-select mode while only the foreign bank's terms move. A wrong bank index would then show up as a change where none should occur. The stimulus holds one bank's terms fixed and toggles the other's through every value. It also sets the macrocell data opposite to the external level, so that any leak into the feedback path changes a visible bit. Mixed-mode random vectors then cover all four modes on every cell together.

// File: rtl/oe_pkg.sv
package oe_pkg;
    typedef enum logic [1:0] {
        OE_OFF    = 2'b00,
        OE_ON     = 2'b01,
        OE_TERM_A = 2'b10,
        OE_TERM_B = 2'b11
    } oe_mode_e;

    localparam int MODE_W       = 2;
    localparam int TERMS_PER_BK = 2;
endpackage

// File: rtl/oe_bank_decode.sv
module oe_bank_decode
    import oe_pkg::*;
#(
    parameter int CELLS = 8
) (
    input  logic [CELLS*MODE_W-1:0] mode_vec,
    input  logic [TERMS_PER_BK-1:0] terms,
    output logic [CELLS-1:0]        oe_vec
);
    typedef struct packed {
        logic [CELLS-1:0] oe;
    } dec_t;

    dec_t dec_d;

    always_comb begin
        dec_d = '0;
        for (int c = 0; c < CELLS; c++) begin
            unique case (oe_mode_e'(mode_vec[c*MODE_W +: MODE_W]))
                OE_OFF:    dec_d.oe[c] = 1'b0;
                OE_ON:     dec_d.oe[c] = 1'b1;
                OE_TERM_A: dec_d.oe[c] = terms[0];
                OE_TERM_B: dec_d.oe[c] = terms[1];
                default:   dec_d.oe[c] = 1'b0;
            endcase
        end
    end

    assign oe_vec = dec_d.oe;
endmodule

// File: rtl/io_pad_cell.sv
module io_pad_cell (
    input  logic data_i,
    input  logic oe_i,
    input  logic ext_i,
    output logic out_o,
    output logic oe_o,
    output logic fb_o
);
    logic pin_d;

    always_comb begin
        pin_d = oe_i ? data_i : ext_i;
    end

    assign out_o = data_i;
    assign oe_o  = oe_i;
    assign fb_o  = pin_d;
endmodule

// File: rtl/oe_bank_ctrl.sv
module oe_bank_ctrl
    import oe_pkg::*;
#(
    parameter int NUM_BANKS      = 2,
    parameter int CELLS_PER_BANK = 8
) (
    input  logic [15:0] mc_data,
    input  logic [3:0]  bank_term,
    input  logic [31:0] cell_mode,
    input  logic [15:0] pad_ext,
    output logic [15:0] pad_out,
    output logic [15:0] pad_oe,
    output logic [15:0] fb_in
);
    localparam int CELLS  = NUM_BANKS * CELLS_PER_BANK;
    localparam int BK_MW  = CELLS_PER_BANK * MODE_W;

    logic [CELLS-1:0] oe_d;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        oe_bank_decode #(.CELLS(CELLS_PER_BANK)) u_dec (
            .mode_vec (cell_mode[b*BK_MW +: BK_MW]),
            .terms    (bank_term[b*TERMS_PER_BK +: TERMS_PER_BK]),
            .oe_vec   (oe_d[b*CELLS_PER_BANK +: CELLS_PER_BANK])
        );
    end

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        io_pad_cell u_cell (
            .data_i (mc_data[c]),
            .oe_i   (oe_d[c]),
            .ext_i  (pad_ext[c]),
            .out_o  (pad_out[c]),
            .oe_o   (pad_oe[c]),
            .fb_o   (fb_in[c])
        );
    end

    // Checks relating top-level inputs to outputs built by the sub-blocks
    always_comb begin
        for (int c = 0; c < CELLS; c++) begin
            if (cell_mode[c*MODE_W +: MODE_W] == 2'b00)
                a_r1_off_low: assert (pad_oe[c] == 1'b0);
            if (cell_mode[c*MODE_W +: MODE_W] == 2'b01)
                a_r2_on_high: assert (pad_oe[c] == 1'b1);
            if (cell_mode[c*MODE_W +: MODE_W] == 2'b10)
                a_r3_first_term: assert (pad_oe[c] == bank_term[(c/CELLS_PER_BANK)*TERMS_PER_BK]);
            if (cell_mode[c*MODE_W +: MODE_W] == 2'b11)
                a_r4_second_term: assert (pad_oe[c] == bank_term[(c/CELLS_PER_BANK)*TERMS_PER_BK+1]);
            a_r6_data_pass: assert (pad_out[c] == mc_data[c]);
            if (!pad_oe[c])
                a_r7_fb_external: assert (fb_in[c] == pad_ext[c]);
            else
                a_r7_fb_driven: assert (fb_in[c] == mc_data[c]);
        end
    end
endmodule

// File: tb/sim_oe_bank_ctrl.sv
module sim_oe_bank_ctrl;
    typedef struct {
        logic [15:0] oe;
        logic [15:0] out;
        logic [15:0] fb;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic [15:0] mc_data = '0;
    logic [3:0]  bank_term = '0;
    logic [31:0] cell_mode = '0;
    logic [15:0] pad_ext = '0;
    logic [15:0] pad_out, pad_oe, fb_in;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    oe_bank_ctrl u0 (
        .mc_data(mc_data), .bank_term(bank_term), .cell_mode(cell_mode),
        .pad_ext(pad_ext), .pad_out(pad_out), .pad_oe(pad_oe), .fb_in(fb_in)
    );

    function automatic exp_t model(input logic [15:0] d, input logic [3:0] t,
                                   input logic [31:0] m, input logic [15:0] e,
                                   input string tag);
        exp_t x;
        x.tag = tag;
        for (int c = 0; c < 16; c++) begin
            logic [1:0] md;
            logic en;
            md = m[2*c +: 2];
            case (md)
                2'b00: en = 1'b0;
                2'b01: en = 1'b1;
                2'b10: en = t[(c < 8) ? 0 : 2];
                default: en = t[(c < 8) ? 1 : 3];
            endcase
            x.oe[c]  = en;
            x.out[c] = d[c];
            x.fb[c]  = en ? d[c] : e[c];
        end
        return x;
    endfunction

    task automatic drive(input logic [15:0] d, input logic [3:0] t,
                         input logic [31:0] m, input logic [15:0] e, input string tag);
        @(negedge clk);
        mc_data = d; bank_term = t; cell_mode = m; pad_ext = e;
        q.push_back(model(d, t, m, e, tag));
    endtask

    task automatic compare(input exp_t x);
        n_cmp++;
        if (pad_oe !== x.oe || pad_out !== x.out || fb_in !== x.fb) begin
            n_bad++;
            $display("FAIL %s: oe=%h out=%h fb=%h expected oe=%h out=%h fb=%h",
                     x.tag, pad_oe, pad_out, fb_in, x.oe, x.out, x.fb);
        end
    endtask

    // monitor: pop and compare half a cycle after each drive
    always @(posedge clk) begin
        if (q.size() > 0) compare(q.pop_front());
    end

    function automatic logic [31:0] all_mode(input logic [1:0] md);
        logic [31:0] r;
        for (int c = 0; c < 16; c++) r[2*c +: 2] = md;
        return r;
    endfunction

    initial begin
        // R1: every cell off, terms high, pad follows outside level
        drive(16'hFFFF, 4'hF, all_mode(2'b00), 16'h5A3C, "R1 all off");
        drive(16'h0000, 4'h0, all_mode(2'b00), 16'hC3A5, "R1 off, terms low");
        // R2 and R6
        drive(16'h1234, 4'h0, all_mode(2'b01), 16'hFFFF, "R2 all on");
        drive(16'hABCD, 4'hF, all_mode(2'b01), 16'h0000, "R6 data pass");
        // R3: first term of each bank
        drive(16'hFFFF, 4'b0001, all_mode(2'b10), 16'h0000, "R3 bank0 A only");
        drive(16'hFFFF, 4'b0100, all_mode(2'b10), 16'h0000, "R3 bank1 A only");
        drive(16'hFFFF, 4'b1010, all_mode(2'b10), 16'h0000, "R3 only B terms set");
        // R4: second term of each bank
        drive(16'hFFFF, 4'b0010, all_mode(2'b11), 16'h0000, "R4 bank0 B only");
        drive(16'hFFFF, 4'b1000, all_mode(2'b11), 16'h0000, "R4 bank1 B only");
        drive(16'hFFFF, 4'b0101, all_mode(2'b11), 16'h0000, "R4 only A terms set");
        // R5: bank 0 in term mode, only bank 1 terms move
        for (int v = 0; v < 4; v++)
            drive(16'h00FF, {v[1:0], 2'b01}, {16'hFFFF, 16'hAAAA}, 16'hFF00,
                  "R5 foreign terms bank0");
        for (int v = 0; v < 4; v++)
            drive(16'hFF00, {2'b10, v[1:0]}, {16'hAAAA, 16'hFFFF}, 16'h00FF,
                  "R5 foreign terms bank1");
        // R7: mixed modes, data opposite to outside level
        drive(16'h0F0F, 4'b0110, 32'hE4E4_E4E4, 16'hF0F0, "R7 mixed modes");
        drive(16'hFFFF, 4'b0000, 32'h0000_5555, 16'h0000, "R7 half driven");
        for (int i = 0; i < 40; i++)
            drive(16'($urandom), 4'($urandom), $urandom, 16'($urandom), "R7 random mix");
        @(negedge clk);
        // R8: change without a clock edge, look 1 ns later
        @(negedge clk);
        #2;
        mc_data = 16'h00FF; bank_term = 4'b0001; cell_mode = all_mode(2'b10); pad_ext = 16'hFF00;
        #1;
        compare(model(16'h00FF, 4'b0001, all_mode(2'b10), 16'hFF00, "R8 no clock needed"));
        bank_term = 4'b0100;
        #1;
        compare(model(16'h00FF, 4'b0100, all_mode(2'b10), 16'hFF00, "R8 second change"));
        @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule